// File: doc/BRIEF.md
# PWM Emergency Trip Guard

This block sits between a multi-channel pulse-width modulator and its output pins. When an external emergency pin goes to its programmed active level, every enabled channel is driven straight away to a programmed safe level. No period boundary is awaited. A single 8-bit control/status register holds the guard enable, the pin polarity, the safe level, an interrupt enable, a sticky change flag, a restart trigger and a read-only copy of the synchronised pin.

Once tripped, the override is latched. Software releases it by writing the restart trigger while the pin is inactive. Each channel then returns to its raw waveform only when its own counter next reports zero, so no channel emits a truncated pulse. Clearing the guard enable behaves the same way: held channels wait for their next counter-zero before they resume. The pin passes through a two-flop synchroniser for flagging, latching and status. Forcing also uses the raw qualified pin, so the reaction needs no clock.

Top module: `pwm_trip_guard`

## Requirements
- R1: While the guard is enabled (bit 0 = 1) and `trip_pin` equals the polarity bit (bit 1, where 1 means active-high), every channel with `ch_en` = 1 drives the safe level on `ch_out` combinationally, in the same cycle, with no clock edge needed.
- R2: A forced channel outputs 0 when the level bit (bit 4) is 0 and outputs 1 when it is 1.
- R3: The flag (bit 7) sets on every change of the synchronised pin, both towards active and towards passive. It sets on the third rising edge after the pin changes.
- R4: Writing 1 to bit 7 clears the flag. Writing 0 to bit 7 leaves the flag unchanged. A pin change in the same cycle as the clearing write takes priority.
- R5: `irq` is high exactly when the flag and the interrupt-enable bit (bit 6) are both 1.
- R6: A write with bit 5 = 1 is accepted only if the synchronised qualified pin is inactive at that write. After an accepted write, each held channel resumes its raw output on the cycle after its `ch_cnt_zero` is first seen high. A rejected write has no effect.
- R7: Bit 5 always reads 0.
- R8: If the guard enable is cleared while channels are held, they stay forced until their counter next passes zero.
- R9: Reset clears the register to 0x00. Bit 3 always reads 0. Bit 2 reads the synchronised pin level.
- R10: If the qualified pin re-asserts while a restart is pending, the pending restart is cancelled and the channels stay forced through later counter-zero pulses.
- R11: Channels with `ch_en` = 0 are never overridden and pass `ch_raw` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| trip_pin | input | 1 | Asynchronous emergency input |
| ch_raw | input | NUM_CH | Raw PWM outputs from the core |
| ch_en | input | NUM_CH | Per-channel enables |
| ch_cnt_zero | input | NUM_CH | Per-channel counter-at-zero indication |
| ch_out | output | NUM_CH | Guarded outputs to the pins |
| irq | output | 1 | Interrupt request |

## Verification
A hold bit stuck high shows up as a channel that stays at the safe level after an accepted restart and a counter-zero pulse. This is visible one cycle after that pulse. A lost or wrongly cleared hold shows up as a raw waveform on a channel that must still be forced. A flag or synchroniser fault shows on `reg_rdata[7]` and `irq` three edges after a pin change. A faulty acceptance test for the restart shows up when a rejected restart is followed by a zero pulse and the outputs are released.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  localparam int BIT_FLAG = 7;
  localparam int BIT_IE   = 6;
  localparam int BIT_RST  = 5;
  localparam int BIT_LVL  = 4;
  localparam int BIT_RSV  = 3;
  localparam int BIT_PIN  = 2;
  localparam int BIT_POL  = 1;
  localparam int BIT_ENA  = 0;
  localparam int REG_W    = 8;

  typedef struct packed {
    logic flag;
    logic ie;
    logic lvl;
    logic pol;
    logic ena;
  } trip_ctrl_t;
endpackage

// File: rtl/pwm_trip_sync.sv
module pwm_trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pwm_trip_ctrl_reg.sv
module pwm_trip_ctrl_reg
  import pwm_trip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             pin_s,
  output trip_ctrl_t       ctrl,
  output logic             trip_act_s,
  output logic             restart_ok,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);
  trip_ctrl_t ctrl_q, ctrl_d;
  logic       pin_prev_q;
  logic       pin_change;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata[BIT_RSV], wdata[BIT_PIN]};

  assign pin_change = (pin_s != pin_prev_q);
  assign trip_act_s = ctrl_q.ena & (pin_s == ctrl_q.pol);
  assign restart_ok = wr_en & wdata[BIT_RST] & ~trip_act_s;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.ie  = wdata[BIT_IE];
      ctrl_d.lvl = wdata[BIT_LVL];
      ctrl_d.pol = wdata[BIT_POL];
      ctrl_d.ena = wdata[BIT_ENA];
      if (wdata[BIT_FLAG]) ctrl_d.flag = 1'b0;
    end
    if (pin_change) ctrl_d.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      pin_prev_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      pin_prev_q <= pin_s;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[BIT_FLAG] = ctrl_q.flag;
    rdata[BIT_IE]   = ctrl_q.ie;
    rdata[BIT_LVL]  = ctrl_q.lvl;
    rdata[BIT_PIN]  = pin_s;
    rdata[BIT_POL]  = ctrl_q.pol;
    rdata[BIT_ENA]  = ctrl_q.ena;
  end

  assign irq  = ctrl_q.flag & ctrl_q.ie;
  assign ctrl = ctrl_q;

  // R3: a synchronised pin change sets the flag
  a_r3_flag_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    pin_change |=> ctrl_q.flag);
  // R4: writing 0 to the flag bit keeps it
  a_r4_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.flag && wr_en && !wdata[BIT_FLAG]) |=> ctrl_q.flag);
  // R4: writing 1 clears it when no change arrives in the same cycle
  a_r4_one_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[BIT_FLAG] && !pin_change) |=> !ctrl_q.flag);
endmodule

// File: rtl/pwm_trip_chan.sv
module pwm_trip_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_act_s,
  input  logic trip_act_raw,
  input  logic restart_ok,
  input  logic guard_ena,
  input  logic safe_lvl,
  input  logic en,
  input  logic raw,
  input  logic cnt_zero,
  output logic out
);
  logic hold_q, hold_d;
  logic pend_q, pend_d;
  logic forced;

  always_comb begin
    hold_d = hold_q;
    pend_d = pend_q;
    if (trip_act_s) begin
      hold_d = 1'b1;
      pend_d = 1'b0;
    end else if (pend_q && cnt_zero) begin
      hold_d = 1'b0;
      pend_d = 1'b0;
    end else if (hold_q && (restart_ok || !guard_ena)) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign forced = en & (hold_q | trip_act_raw);
  assign out    = forced ? safe_lvl : raw;

  // R6: a held channel only releases on a counter-zero cycle
  a_r6_hold_until_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !cnt_zero) |=> hold_q);
  // R10: an active qualified pin cancels any pending restart
  a_r10_cancel_pending: assert property (@(posedge clk) disable iff (!rst_n)
    trip_act_s |=> (hold_q && !pend_q));
  // R1, R11: an enabled channel under a raw trip shows the safe level, a disabled one the raw value
  a_r1_force_now: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trip_act_raw) |-> (out == safe_lvl));
  a_r11_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (out == raw));
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
  import pwm_trip_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              trip_pin,
  input  logic [NUM_CH-1:0] ch_raw,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_cnt_zero,
  output logic [NUM_CH-1:0] ch_out,
  output logic              irq
);
  logic       pin_s;
  logic       trip_act_s;
  logic       trip_act_raw;
  logic       restart_ok;
  trip_ctrl_t ctrl;

  pwm_trip_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(trip_pin), .q(pin_s)
  );

  pwm_trip_ctrl_reg reg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .pin_s(pin_s), .ctrl(ctrl), .trip_act_s(trip_act_s),
    .restart_ok(restart_ok), .rdata(reg_rdata), .irq(irq)
  );

  assign trip_act_raw = ctrl.ena & (trip_pin == ctrl.pol);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_trip_chan chan_i (
      .clk(clk), .rst_n(rst_n),
      .trip_act_s(trip_act_s), .trip_act_raw(trip_act_raw),
      .restart_ok(restart_ok), .guard_ena(ctrl.ena), .safe_lvl(ctrl.lvl),
      .en(ch_en[g]), .raw(ch_raw[g]), .cnt_zero(ch_cnt_zero[g]),
      .out(ch_out[g])
    );
  end

  // R7, R9: the restart and reserved bits never read back as 1
  a_r7_restart_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_rdata[BIT_RST] == 1'b0 && reg_rdata[BIT_RSV] == 1'b0));
  // R5: an interrupt request implies the enable bit reads back as 1
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> reg_rdata[BIT_IE]);
endmodule

// File: tb/pwm_trip_guard_tb_top.sv
module pwm_trip_guard_tb_top;
  localparam int N = 6;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr_en;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic trip_pin;
  logic [N-1:0] ch_raw, ch_en, ch_cnt_zero, ch_out;
  logic irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_trip_guard #(.NUM_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trip_pin(trip_pin), .ch_raw(ch_raw), .ch_en(ch_en),
    .ch_cnt_zero(ch_cnt_zero), .ch_out(ch_out), .irq(irq)
  );

  // act_hi, lvl, pin, en, raw, expected out
  typedef struct packed {
    logic act_hi; logic lvl; logic pin;
    logic [5:0] en; logic [5:0] raw; logic [5:0] exp;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 1'b0, 6'h3F, 6'h2A, 6'h2A},
    '{1'b1, 1'b0, 1'b1, 6'h3F, 6'h2A, 6'h00},
    '{1'b1, 1'b1, 1'b1, 6'h0F, 6'h00, 6'h0F},
    '{1'b0, 1'b1, 1'b0, 6'h3F, 6'h15, 6'h3F},
    '{1'b0, 1'b0, 1'b0, 6'h30, 6'h3F, 6'h0F},
    '{1'b0, 1'b1, 1'b1, 6'h3F, 6'h11, 6'h11}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_en = 1'b1; reg_wdata = d;
    tick(1);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic zero_pulse(input logic [N-1:0] m);
    ch_cnt_zero = m;
    tick(1);
    ch_cnt_zero = '0;
  endtask

  // ctl = {ie, lvl, pol, ena}; restart and flag-clear chosen per write
  function automatic logic [7:0] cw(input logic clr, input logic ie, input logic rs,
                                    input logic lvl, input logic pol, input logic ena);
    return {clr, ie, rs, lvl, 2'b00, pol, ena};
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0; trip_pin = 1'b0;
    ch_raw = 6'h2D; ch_en = ALL; ch_cnt_zero = '0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R9 reset state
    chk("R9 reset reg", reg_rdata, 8'h00);
    chk("R11 reset passthrough", {2'b0, ch_out}, {2'b0, ch_raw});
    chk("R5 reset irq", {7'b0, irq}, 8'h00);

    // vector table: immediate forcing, levels, polarity, disabled channels
    foreach (VECS[i]) begin
      trip_pin = ~VECS[i].act_hi;
      wr(cw(1'b1, 1'b0, 1'b0, VECS[i].lvl, VECS[i].act_hi, 1'b1));
      tick(3);
      wr(cw(1'b1, 1'b0, 1'b1, VECS[i].lvl, VECS[i].act_hi, 1'b1));
      zero_pulse(ALL);
      ch_en = VECS[i].en; ch_raw = VECS[i].raw;
      trip_pin = VECS[i].pin;
      #1;
      chk($sformatf("R1 R2 R11 vector %0d", i), {2'b0, ch_out}, {2'b0, VECS[i].exp});
      tick(1);
    end
    trip_pin = 1'b0;
    ch_en = ALL; ch_raw = 6'h2D;
    wr(cw(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    tick(3);
    wr(cw(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    zero_pulse(ALL);
    wr(cw(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1));
    chk("R4 flag clear by one", {7'b0, reg_rdata[7]}, 8'h00);

    // R3 flag timing and R5 irq
    trip_pin = 1'b1;
    tick(2);
    chk("R3 flag not yet set", {7'b0, reg_rdata[7]}, 8'h00);
    tick(1);
    chk("R3 flag set on assert", {7'b0, reg_rdata[7]}, 8'h01);
    chk("R9 pin status bit", {7'b0, reg_rdata[2]}, 8'h01);
    chk("R5 irq with enable", {7'b0, irq}, 8'h01);
    wr(cw(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1));
    chk("R4 zero write keeps flag", {7'b0, reg_rdata[7]}, 8'h01);
    wr(cw(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
    chk("R5 irq off without enable", {7'b0, irq}, 8'h00);

    // R6 restart rejected while pin active
    wr(cw(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1));
    chk("R7 restart reads zero", {7'b0, reg_rdata[5]}, 8'h00);
    trip_pin = 1'b0;
    tick(3);
    chk("R3 flag set on deassert", {7'b0, reg_rdata[7]}, 8'h01);
    zero_pulse(ALL);
    tick(1);
    chk("R6 rejected restart stays forced", {2'b0, ch_out}, 8'h3F);

    // R6 accepted restart, per-channel release
    wr(cw(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1));
    chk("R6 forced before zero", {2'b0, ch_out}, 8'h3F);
    zero_pulse(6'h01);
    chk("R6 channel 0 released only", {2'b0, ch_out}, {2'b0, 6'h3E | (ch_raw & 6'h01)});
    zero_pulse(ALL);
    chk("R6 all released", {2'b0, ch_out}, {2'b0, ch_raw});

    // R10 cancel pending restart on re-assert
    trip_pin = 1'b1; tick(3); trip_pin = 1'b0; tick(3);
    wr(cw(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1));
    trip_pin = 1'b1; tick(3); trip_pin = 1'b0; tick(3);
    zero_pulse(ALL);
    tick(1);
    chk("R10 cancelled restart stays forced", {2'b0, ch_out}, 8'h3F);

    // R8 guard disable waits for counter zero
    wr(cw(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
    tick(2);
    chk("R8 forced after disable", {2'b0, ch_out}, 8'h3F);
    zero_pulse(ALL);
    chk("R8 released at zero", {2'b0, ch_out}, {2'b0, ch_raw});
    chk("R9 reserved bit", {7'b0, reg_rdata[3]}, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule